// File: doc/BRIEF.md
# Processing Element Dual Watchdog

This block supervises a bank of processing elements with two timeout counters per element. The compute timer limits how long an element may spend on a job. It is armed by a pulse saying that all input data for the job has been delivered. It is disarmed when the element lowers its running flag. The bus-hold timer limits how long an element may occupy the shared output bus. It is armed by the scheduler's output acknowledge and disarmed when the element lowers its output-valid flag.

If a timer runs out while its hold flag is still high, the block issues a one-cycle reset pulse to that element. In the same cycle it raises a drop flag that tells which timer tripped, so downstream logic can discard the element's unfinished data. Each element's two limits are written once through a small configuration port at initialization. A limit of zero switches that timer off.

Top module: `pe_dual_watchdog`

## Requirements
- R1: After the synchronous reset, every reset pulse and drop flag is low and every limit reads as zero, so no timer can arm until a limit is written.
- R2: A configuration write with `cfg_we` high stores `cfg_limit` for element `cfg_idx`, selecting the compute timer when `cfg_kind` is 0 and the bus-hold timer when it is 1. A write with an index of `NUM_PE` or above changes no limit.
- R3: A compute timer armed by `load_done[i]` at clock edge E0, with `running[i]` high at each of edges E1..EL (L = limit), raises `pe_rst[i]` together with `drop_proc[i]` in the cycle after edge EL.
- R4: If `running[i]` is sampled low at any edge from E1 through EL, the compute timer disarms and no reset is produced.
- R5: A bus-hold timer armed by `out_ack[i]` at edge E0, with `out_valid[i]` high at edges E1..EL, raises `pe_rst[i]` together with `drop_bus[i]` in the cycle after edge EL.
- R6: If `out_valid[i]` is sampled low at any edge from E1 through EL, the bus-hold timer disarms and no reset is produced.
- R7: Each trip yields exactly one reset pulse, one cycle long. A drop flag is high only in a cycle where that element's reset is high.
- R8: A start event for a timer whose limit is zero is ignored, and no reset follows however long the hold flag stays high.
- R9: The elements are independent. Events on one element never produce a reset on another, and every element can time out in the same run with its own limit.
- R10: When one timer of an element trips, the other timer of that element is cancelled. It produces no second reset for the same job.
- R11: A start event that arrives while a timer is armed restarts its count from that edge. No trip is reported in the cycle right after a start event for that timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Limit write strobe |
| cfg_kind | input | 1 | Timer select for the write: 0 compute, 1 bus-hold |
| cfg_idx | input | IDX_W | Element index for the write |
| cfg_limit | input | CNT_W | Limit in cycles; 0 disables the timer |
| load_done | input | NUM_PE | Per element: input delivery complete (arms compute timer) |
| running | input | NUM_PE | Per element: computation in progress |
| out_ack | input | NUM_PE | Per element: output acknowledged (arms bus-hold timer) |
| out_valid | input | NUM_PE | Per element: element is driving the output bus |
| pe_rst | output | NUM_PE | Per element: one-cycle reset pulse |
| drop_proc | output | NUM_PE | Per element: compute timer tripped, drop data |
| drop_bus | output | NUM_PE | Per element: bus-hold timer tripped, drop data |

## Verification
The main sweep covers every element, both timer kinds and limits from 1 to 5. For each limit, the hold flag is released after every duration from zero up to one past the limit. This separates an off-by-one in the expiry compare from a correct boundary, and it shows whether the drop flag names the right timer. Further patterns arm all elements at once with different limits, to show they are independent, and re-arm a running timer, to show the count restarts. Other patterns trip one timer while the sibling is still armed, to show the sibling is cancelled. The remaining patterns use zero limits and out-of-range configuration indexes, to show that such writes or starts have no effect.

// File: rtl/pe_wd_pkg.sv
package pe_wd_pkg;

    localparam int unsigned PE_COUNT_DEF = 5;
    localparam int unsigned CNT_W_DEF    = 8;

    typedef enum logic {
        TMR_COMPUTE = 1'b0,
        TMR_BUSHOLD = 1'b1
    } tmr_kind_e;

    typedef struct packed {
        logic compute_trip;
        logic bus_trip;
    } trip_t;

    function automatic int unsigned idx_width(int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pe_wd_limits.sv
module pe_wd_limits
    import pe_wd_pkg::*;
#(
    parameter int unsigned NUM_PE = PE_COUNT_DEF,
    parameter int unsigned CNT_W  = CNT_W_DEF,
    parameter int unsigned IDX_W  = idx_width(NUM_PE)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  tmr_kind_e                      wr_kind,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [CNT_W-1:0]               wr_val,
    output logic [NUM_PE-1:0][CNT_W-1:0]   lim_compute,
    output logic [NUM_PE-1:0][CNT_W-1:0]   lim_bus
);

    for (genvar i = 0; i < NUM_PE; i++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                lim_compute[i] <= '0;
                lim_bus[i]     <= '0;
            end else if (hit) begin
                if (wr_kind == TMR_BUSHOLD) begin
                    lim_bus[i] <= wr_val;
                end else begin
                    lim_compute[i] <= wr_val;
                end
            end
        end
    end

endmodule

// File: rtl/pe_wd_timer.sv
module pe_wd_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cancel,
    input  logic             start,
    input  logic             hold,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             armed;
    logic [CNT_W-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            elapsed <= '0;
            fire    <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (cancel) begin
                armed <= 1'b0;
            end else if (start) begin
                armed   <= (limit != '0);
                elapsed <= '0;
            end else if (armed) begin
                if (!hold) begin
                    armed <= 1'b0;
                end else if (elapsed == limit - ONE) begin
                    fire  <= 1'b1;
                    armed <= 1'b0;
                end else begin
                    elapsed <= elapsed + ONE;
                end
            end
        end
    end

endmodule

// File: rtl/pe_dual_watchdog.sv
module pe_dual_watchdog
    import pe_wd_pkg::*;
#(
    parameter int unsigned NUM_PE = PE_COUNT_DEF,
    parameter int unsigned CNT_W  = CNT_W_DEF,
    parameter int unsigned IDX_W  = idx_width(NUM_PE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_kind,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CNT_W-1:0]  cfg_limit,
    input  logic [NUM_PE-1:0] load_done,
    input  logic [NUM_PE-1:0] running,
    input  logic [NUM_PE-1:0] out_ack,
    input  logic [NUM_PE-1:0] out_valid,
    output logic [NUM_PE-1:0] pe_rst,
    output logic [NUM_PE-1:0] drop_proc,
    output logic [NUM_PE-1:0] drop_bus
);

    logic [NUM_PE-1:0][CNT_W-1:0] lim_compute;
    logic [NUM_PE-1:0][CNT_W-1:0] lim_bus;
    tmr_kind_e                    kind_sel;
    trip_t                        trips [NUM_PE];

    assign kind_sel = tmr_kind_e'(cfg_kind);

    pe_wd_limits #(
        .NUM_PE (NUM_PE),
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W)
    ) u_limits (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cfg_we),
        .wr_kind     (kind_sel),
        .wr_idx      (cfg_idx),
        .wr_val      (cfg_limit),
        .lim_compute (lim_compute),
        .lim_bus     (lim_bus)
    );

    for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
        logic kill;
        assign kill = trips[i].compute_trip | trips[i].bus_trip;

        pe_wd_timer #(.CNT_W(CNT_W)) u_compute (
            .clk    (clk),
            .rst    (rst),
            .cancel (kill),
            .start  (load_done[i]),
            .hold   (running[i]),
            .limit  (lim_compute[i]),
            .fire   (trips[i].compute_trip)
        );

        pe_wd_timer #(.CNT_W(CNT_W)) u_bushold (
            .clk    (clk),
            .rst    (rst),
            .cancel (kill),
            .start  (out_ack[i]),
            .hold   (out_valid[i]),
            .limit  (lim_bus[i]),
            .fire   (trips[i].bus_trip)
        );

        assign pe_rst[i]    = kill;
        assign drop_proc[i] = trips[i].compute_trip;
        assign drop_bus[i]  = trips[i].bus_trip;
    end

endmodule

// File: rtl/pe_dual_watchdog_chk.sv
module pe_dual_watchdog_chk #(
    parameter int unsigned NUM_PE = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_PE-1:0] load_done,
    input logic [NUM_PE-1:0] running,
    input logic [NUM_PE-1:0] out_ack,
    input logic [NUM_PE-1:0] out_valid,
    input logic [NUM_PE-1:0] pe_rst,
    input logic [NUM_PE-1:0] drop_proc,
    input logic [NUM_PE-1:0] drop_bus
);

    AST_QUIET_AFTER_RST: assert property (@(posedge clk) $past(rst) |-> (pe_rst == '0)); // R1

    for (genvar i = 0; i < NUM_PE; i++) begin : g_e
        AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) pe_rst[i] |=> !pe_rst[i]); // R7
        AST_PROC_HELD: assert property (@(posedge clk) disable iff (rst) drop_proc[i] |-> $past(running[i])); // R4
        AST_BUS_HELD: assert property (@(posedge clk) disable iff (rst) drop_bus[i] |-> $past(out_valid[i])); // R6
        AST_PROC_NOT_ON_START: assert property (@(posedge clk) disable iff (rst) drop_proc[i] |-> !$past(load_done[i])); // R11
        AST_BUS_NOT_ON_START: assert property (@(posedge clk) disable iff (rst) drop_bus[i] |-> !$past(out_ack[i])); // R11
    end

endmodule

bind pe_dual_watchdog pe_dual_watchdog_chk #(.NUM_PE(NUM_PE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load_done (load_done),
    .running   (running),
    .out_ack   (out_ack),
    .out_valid (out_valid),
    .pe_rst    (pe_rst),
    .drop_proc (drop_proc),
    .drop_bus  (drop_bus)
);

// File: tb/test_pe_dual_watchdog.sv
`timescale 1ns/1ps
module test_pe_dual_watchdog;

    localparam int NPE = 5;
    localparam int CW  = 8;
    localparam int IW  = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_we = 1'b0;
    logic           cfg_kind = 1'b0;
    logic [IW-1:0]  cfg_idx = '0;
    logic [CW-1:0]  cfg_limit = '0;
    logic [NPE-1:0] load_done = '0;
    logic [NPE-1:0] running = '0;
    logic [NPE-1:0] out_ack = '0;
    logic [NPE-1:0] out_valid = '0;
    logic [NPE-1:0] pe_rst;
    logic [NPE-1:0] drop_proc;
    logic [NPE-1:0] drop_bus;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // per-run observations
    int pulses [NPE];
    int first_at [NPE];
    int kind_bad [NPE];

    always #4 clk = ~clk;

    pe_dual_watchdog #(.NUM_PE(NPE), .CNT_W(CW), .IDX_W(IW)) i_pe_dual_watchdog (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_kind),
        .cfg_idx   (cfg_idx),
        .cfg_limit (cfg_limit),
        .load_done (load_done),
        .running   (running),
        .out_ack   (out_ack),
        .out_valid (out_valid),
        .pe_rst    (pe_rst),
        .drop_proc (drop_proc),
        .drop_bus  (drop_bus)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_limit(input int e, input int kind, input int lim);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_kind  = kind[0];
        cfg_idx   = IW'(e);
        cfg_limit = CW'(lim);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic clear_obs();
        for (int e = 0; e < NPE; e++) begin
            pulses[e] = 0; first_at[e] = 0; kind_bad[e] = 0;
        end
    endtask

    // sample at a negedge, k = edges since arming edge; kind: 0 compute 1 bus
    task automatic observe(input int k, input int kind);
        for (int e = 0; e < NPE; e++) begin
            if (pe_rst[e]) begin
                pulses[e]++;
                if (first_at[e] == 0) first_at[e] = k;
                if (kind == 0 && !(drop_proc[e] && !drop_bus[e])) kind_bad[e]++;
                if (kind == 1 && !(drop_bus[e] && !drop_proc[e])) kind_bad[e]++;
            end
            if ((drop_proc[e] || drop_bus[e]) && !pe_rst[e]) kind_bad[e]++;
        end
    endtask

    task automatic set_start(input int kind, input logic [NPE-1:0] v);
        if (kind == 0) load_done = v; else out_ack = v;
    endtask

    task automatic set_hold(input int kind, input logic [NPE-1:0] v);
        if (kind == 0) running = v; else out_valid = v;
    endtask

    task automatic idle(input int n);
        load_done = '0; out_ack = '0; running = '0; out_valid = '0;
        repeat (n) @(negedge clk);
    endtask

    // arm element e, keep hold high for edges 1..d, watch span edges
    task automatic run_case(input int e, input int kind, input int d, input int span);
        logic [NPE-1:0] m;
        m = NPE'(1) << e;
        clear_obs();
        @(negedge clk);
        set_start(kind, m);
        set_hold(kind, m);
        @(negedge clk);
        set_start(kind, '0);
        set_hold(kind, (d >= 1) ? m : '0);
        for (int k = 1; k <= span; k++) begin
            @(negedge clk);
            observe(k, kind);
            set_hold(kind, (k + 1 <= d) ? m : '0);
        end
        idle(2);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs quiet after reset
        check(pe_rst == '0 && drop_proc == '0 && drop_bus == '0, "R1 outputs after reset",
              int'(pe_rst), 0);
        // R1: limits cleared by reset
        write_limit(0, 0, 2);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        run_case(0, 0, 10, 10);
        check(pulses[0] == 0, "R1 limit cleared by reset", pulses[0], 0);

        // R3 R4 R5 R6 R7: sweep elements, kinds, limits, hold durations
        for (int kind = 0; kind < 2; kind++) begin
            for (int e = 0; e < NPE; e++) begin
                for (int lim = 1; lim <= 5; lim++) begin
                    write_limit(e, kind, lim);
                    for (int d = 0; d <= lim + 1; d++) begin
                        automatic int exp_at = (d >= lim) ? lim : 0;
                        automatic int others = 0;
                        run_case(e, kind, d, lim + 3);
                        for (int o = 0; o < NPE; o++) if (o != e) others += pulses[o];
                        if (kind == 0) begin
                            check(first_at[e] == exp_at, (d >= lim) ? "R3 compute trip cycle" : "R4 compute stop",
                                  first_at[e], exp_at);
                        end else begin
                            check(first_at[e] == exp_at, (d >= lim) ? "R5 bus trip cycle" : "R6 bus stop",
                                  first_at[e], exp_at);
                        end
                        check(pulses[e] == ((d >= lim) ? 1 : 0) && kind_bad[e] == 0,
                              "R7 single pulse and drop flag", pulses[e] * 10 + kind_bad[e],
                              (d >= lim) ? 10 : 0);
                        check(others == 0, "R9 no reset on other elements", others, 0);
                    end
                    write_limit(e, kind, 0);
                end
            end
        end

        // R8: zero limit ignores starts
        for (int kind = 0; kind < 2; kind++) begin
            write_limit(3, kind, 0);
            run_case(3, kind, 20, 20);
            check(pulses[3] == 0, "R8 zero limit disables", pulses[3], 0);
        end

        // R2: out-of-range indexes leave all limits at zero
        for (int ix = NPE; ix < 8; ix++) begin
            write_limit(ix, 0, 2);
            write_limit(ix, 1, 2);
        end
        for (int kind = 0; kind < 2; kind++) begin
            for (int e = 0; e < NPE; e++) begin
                run_case(e, kind, 8, 8);
                check(pulses[e] == 0, "R2 out-of-range write ignored", pulses[e], 0);
            end
        end
        // R2: kind select routes to the right timer
        write_limit(4, 1, 3);
        run_case(4, 0, 8, 8);
        check(pulses[4] == 0, "R2 bus limit does not arm compute", pulses[4], 0);
        run_case(4, 1, 8, 8);
        check(first_at[4] == 3, "R2 bus limit arms bus timer", first_at[4], 3);
        write_limit(4, 1, 0);

        // R9: all elements at once with their own limits
        for (int e = 0; e < NPE; e++) write_limit(e, 0, e + 1);
        clear_obs();
        @(negedge clk); load_done = '1; running = '1;
        @(negedge clk); load_done = '0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            observe(k, 0);
        end
        idle(2);
        for (int e = 0; e < NPE; e++) begin
            check(first_at[e] == e + 1 && pulses[e] == 1, "R9 parallel independent trips", first_at[e], e + 1);
        end

        // R10: compute trip cancels bus-hold timer of same element
        write_limit(1, 0, 3);
        write_limit(1, 1, 5);
        clear_obs();
        @(negedge clk); load_done = 5'b00010; out_ack = 5'b00010; running = 5'b00010; out_valid = 5'b00010;
        @(negedge clk); load_done = '0; out_ack = '0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            observe(k, 0);
        end
        idle(2);
        check(first_at[1] == 3 && pulses[1] == 1 && kind_bad[1] == 0, "R10 sibling timer cancelled",
              pulses[1], 1);

        // R11: re-arm restarts the count
        write_limit(2, 0, 4);
        clear_obs();
        @(negedge clk); load_done = 5'b00100; running = 5'b00100;
        @(negedge clk); load_done = '0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            observe(k, 0);
            load_done = (k == 1) ? 5'b00100 : 5'b00000;
        end
        idle(2);
        check(first_at[2] == 6 && pulses[2] == 1, "R11 restart on new start", first_at[2], 6);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule